// File: doc/BRIEF.md
# Spectral Power Averager and Detector

This block sits behind a streaming FFT and turns its complex bins into a power spectrum. Every bin gives a power value, the sum of the squares of its real and imaginary parts. That power is added into a running per-bin sum held in an on-chip RAM. The sum covers a programmable number of consecutive frames, always a power of two. In the last frame of each averaging period the block divides the sum by a right shift and emits one averaged power per bin. Each output word carries the bin index and a detect flag, which is set when the averaged power is above a programmed threshold. With averaging set to one frame, every frame passes straight through. With longer periods the output rate falls by the averaging factor.

Frames are delimited by a first-bin marker and are checked against the programmed frame length. A frame that ends early is detected when the next first-bin marker arrives. A frame that runs past its length is detected at the extra bin. Either case raises a one-cycle error pulse and discards the averaging period in progress. Frame length and averaging count are captured when a period begins. The threshold is used live. The RAM depth is set by a parameter: 2^BIN_AW bins. Frames of 8192 bins need BIN_AW = 13.

Top module: `spec_avg_detect`

## Requirements
- R1: Bin power is in_re*in_re + in_im*in_im, with both inputs taken as signed two's complement. The result is unsigned and 2*DATA_W bits wide, so the full-scale case (-2^(DATA_W-1) on both parts) reads 2^(2*DATA_W-1).
- R2: With cfg_avg_log2 = 0, every accepted bin of every frame produces exactly one output word. Words come out in arrival order, and out_bin runs 0 .. cfg_frame_len-1 within a frame.
- R3: With cfg_avg_log2 = k (1..8), outputs appear only during the last frame of each period of 2^k frames. Each word is floor(sum of the 2^k bin powers / 2^k). The first frame of a period overwrites the stored sums, so an earlier period never leaks into a later one.
- R4: out_detect is 1 exactly when out_power is strictly greater than cfg_threshold. Equality gives 0.
- R5: A bin accepted at rising edge e produces its output word (when one is due) with out_valid high from edge e+1 to edge e+2. out_valid is low one cycle earlier.
- R6: A frame length of 1, with one bin every clock, accumulates correctly, because a sum written in one cycle is used by the next read of the same bin.
- R7: If in_first arrives before cfg_frame_len bins of the open frame were accepted, err_frame pulses high for one cycle after that edge. The new frame then becomes the first frame of a fresh period.
- R8: A bin that arrives without in_first after cfg_frame_len bins of a frame raises err_frame for one cycle. That bin, and every later bin up to the next in_first, is ignored. The next in_first begins a fresh period.
- R9: A bin with in_first = 0 while no frame is open (after reset, or after an R8 error) is ignored and raises no error.
- R10: While in reset and in the cycle after it, out_valid and err_frame are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bin is present on in_re/in_im |
| in_first | input | 1 | The present bin is bin 0 of a frame |
| in_re | input | DATA_W | Real part, signed |
| in_im | input | DATA_W | Imaginary part, signed |
| cfg_frame_len | input | BIN_AW+1 | Bins per frame, 1 .. 2^BIN_AW |
| cfg_avg_log2 | input | LOG_W | log2 of frames per period; values above MAX_LOG act as MAX_LOG |
| cfg_threshold | input | 2*DATA_W | Detection threshold |
| out_valid | output | 1 | Output word present |
| out_power | output | 2*DATA_W | Averaged bin power |
| out_bin | output | BIN_AW | Bin index of the word |
| out_detect | output | 1 | Averaged power above threshold |
| err_frame | output | 1 | One-cycle pulse on a frame length error |

## Verification
Three situations are hard to reach from the ports.

The first is the read-after-write hazard on the sum RAM. It only shows when the same bin index returns in consecutive cycles, so the stimulus runs frames of one bin back to back with two-frame averaging.

The second is full-width accumulation. A 256-frame period that feeds full-scale negative samples into one bin drives the sum up to its top bit.

The third is recovery from frame errors in the middle of a period. Frames cut short or overlong are injected after partial accumulation. The outputs must then reflect only the frames of the new period.

// File: rtl/spa_pkg.sv
package spa_pkg;
   // classification of an arriving bin against the open frame
   typedef enum logic [2:0] {
      CHK_NONE,
      CHK_START,
      CHK_CONT,
      CHK_SHORT,
      CHK_LONG
   } chk_e;
endpackage

// File: rtl/spa_power.sv
module spa_power #(
   parameter int DATA_W = 16
) (
   input  logic signed [DATA_W-1:0]   re,
   input  logic signed [DATA_W-1:0]   im,
   output logic        [2*DATA_W-1:0] pwr
);
   localparam int PW = 2*DATA_W;

   logic signed [PW-1:0] re_sq;
   logic signed [PW-1:0] im_sq;

   always_comb begin
      re_sq = PW'(re) * PW'(re);
      im_sq = PW'(im) * PW'(im);
      pwr   = $unsigned(re_sq) + $unsigned(im_sq);
   end
endmodule

// File: rtl/spa_bin_ram.sv
module spa_bin_ram #(
   parameter int AW = 10,
   parameter int DW = 40
) (
   input  logic          clk,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // read returns the contents before a same-cycle write
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/spa_frame_ctl.sv
module spa_frame_ctl
   import spa_pkg::*;
#(
   parameter int BIN_AW  = 10,
   parameter int MAX_LOG = 8,
   parameter int LOG_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic [BIN_AW:0]   cfg_len,
   input  logic [LOG_W-1:0]  cfg_log,
   output logic              acc,
   output logic [BIN_AW-1:0] acc_bin,
   output logic              acc_first,
   output logic              acc_last,
   output logic [LOG_W-1:0]  acc_shift,
   output logic              err
);
   localparam int IW = MAX_LOG + 1;

   logic               in_frame;
   logic [BIN_AW:0]    bin_cnt;
   logic [MAX_LOG-1:0] frm_idx;
   logic [BIN_AW:0]    len_q;
   logic [LOG_W-1:0]   log_q;

   chk_e               kind;
   logic               full;
   logic               starting;
   logic               period_start;
   logic [LOG_W-1:0]   log_clamp;
   logic [LOG_W-1:0]   eff_log;
   logic [IW-1:0]      last_cur;
   logic [IW-1:0]      last_eff;
   logic [MAX_LOG-1:0] next_idx;

   always_comb begin
      log_clamp = (cfg_log > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : cfg_log;
      full      = (bin_cnt == len_q);
      last_cur  = (IW'(1) << log_q) - IW'(1);

      kind = CHK_NONE;
      if (in_valid) begin
         if (in_first)      kind = (in_frame && !full) ? CHK_SHORT : CHK_START;
         else if (in_frame) kind = full ? CHK_LONG : CHK_CONT;
      end

      starting     = (kind == CHK_START) || (kind == CHK_SHORT);
      period_start = starting &&
                     (!in_frame || (kind == CHK_SHORT) || ({1'b0, frm_idx} == last_cur));
      next_idx     = period_start ? '0 : (starting ? frm_idx + 1'b1 : frm_idx);
      eff_log      = period_start ? log_clamp : log_q;
      last_eff     = (IW'(1) << eff_log) - IW'(1);

      acc       = starting || (kind == CHK_CONT);
      acc_bin   = starting ? '0 : bin_cnt[BIN_AW-1:0];
      acc_first = (next_idx == '0);
      acc_last  = ({1'b0, next_idx} == last_eff);
      acc_shift = eff_log;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         bin_cnt  <= '0;
         frm_idx  <= '0;
         len_q    <= '0;
         log_q    <= '0;
         err      <= 1'b0;
      end else begin
         err <= (kind == CHK_SHORT) || (kind == CHK_LONG);
         if (starting) begin
            in_frame <= 1'b1;
            bin_cnt  <= (BIN_AW+1)'(1);
            frm_idx  <= next_idx;
            if (period_start) begin
               len_q <= cfg_len;
               log_q <= log_clamp;
            end
         end else if (kind == CHK_CONT) begin
            bin_cnt <= bin_cnt + 1'b1;
         end else if (kind == CHK_LONG) begin
            in_frame <= 1'b0;
         end
      end
   end

   // R8
   err_after_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(in_valid));

   // R9
   idle_bin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_first && !in_frame) |=> !err);
endmodule

// File: rtl/spa_accum.sv
module spa_accum #(
   parameter int BIN_AW  = 10,
   parameter int POW_W   = 32,
   parameter int SUM_W   = 40,
   parameter int MAX_LOG = 8,
   parameter int LOG_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [BIN_AW-1:0] acc_bin,
   input  logic              acc_first,
   input  logic              acc_last,
   input  logic [LOG_W-1:0]  acc_shift,
   input  logic [POW_W-1:0]  pwr,
   input  logic [POW_W-1:0]  thr,
   input  logic [SUM_W-1:0]  rd_data,
   output logic              wr_en,
   output logic [BIN_AW-1:0] wr_addr,
   output logic [SUM_W-1:0]  wr_data,
   output logic              out_valid,
   output logic [POW_W-1:0]  out_power,
   output logic [BIN_AW-1:0] out_bin,
   output logic              out_detect
);
   logic              b_valid;
   logic [BIN_AW-1:0] b_bin;
   logic              b_first;
   logic              b_last;
   logic [LOG_W-1:0]  b_shift;
   logic [POW_W-1:0]  b_pwr;

   logic              fw_valid;
   logic [BIN_AW-1:0] fw_addr;
   logic [SUM_W-1:0]  fw_data;

   logic [SUM_W-1:0]  old_sum;
   logic [SUM_W-1:0]  new_sum;
   logic [POW_W-1:0]  avg;
   logic [POW_W-1:0]  shifted [MAX_LOG+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_valid  <= 1'b0;
         fw_valid <= 1'b0;
      end else begin
         b_valid  <= acc;
         fw_valid <= wr_en;
      end
   end

   always_ff @(posedge clk) begin
      b_bin   <= acc_bin;
      b_first <= acc_first;
      b_last  <= acc_last;
      b_shift <= acc_shift;
      b_pwr   <= pwr;
      fw_addr <= wr_addr;
      fw_data <= wr_data;
   end

   always_comb begin
      old_sum = (fw_valid && (fw_addr == b_bin)) ? fw_data : rd_data;
      new_sum = (b_first ? '0 : old_sum) + SUM_W'(b_pwr);
      wr_en   = b_valid;
      wr_addr = b_bin;
      wr_data = new_sum;
   end

   for (genvar g = 0; g <= MAX_LOG; g++) begin : g_shift
      assign shifted[g] = POW_W'(new_sum >> g);
   end

   assign avg = shifted[b_shift];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_detect <= 1'b0;
      end else begin
         out_valid  <= b_valid && b_last;
         out_detect <= b_valid && b_last && (avg > thr);
      end
   end

   always_ff @(posedge clk) begin
      out_power <= avg;
      out_bin   <= b_bin;
   end

   // R4
   detect_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_detect |-> (out_valid && (out_power > $past(thr))));

   // R4
   quiet_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_detect) |-> (out_power <= $past(thr)));
endmodule

// File: rtl/spec_avg_detect.sv
module spec_avg_detect #(
   parameter int DATA_W  = 16,
   parameter int BIN_AW  = 10,
   parameter int MAX_LOG = 8,
   localparam int POW_W  = 2*DATA_W,
   localparam int SUM_W  = POW_W + MAX_LOG,
   localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_first,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   input  logic [BIN_AW:0]          cfg_frame_len,
   input  logic [LOG_W-1:0]         cfg_avg_log2,
   input  logic [POW_W-1:0]         cfg_threshold,
   output logic                     out_valid,
   output logic [POW_W-1:0]         out_power,
   output logic [BIN_AW-1:0]        out_bin,
   output logic                     out_detect,
   output logic                     err_frame
);
   if (DATA_W < 2 || BIN_AW < 1 || MAX_LOG < 1 || MAX_LOG > 16) begin : g_bad_cfg
      $error("spec_avg_detect: parameter out of supported range");
   end

   logic              acc;
   logic [BIN_AW-1:0] acc_bin;
   logic              acc_first;
   logic              acc_last;
   logic [LOG_W-1:0]  acc_shift;
   logic [POW_W-1:0]  pwr;
   logic [SUM_W-1:0]  rd_data;
   logic              wr_en;
   logic [BIN_AW-1:0] wr_addr;
   logic [SUM_W-1:0]  wr_data;

   spa_power #(.DATA_W(DATA_W)) u_power (
      .re  (in_re),
      .im  (in_im),
      .pwr (pwr)
   );

   spa_frame_ctl #(.BIN_AW(BIN_AW), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_first  (in_first),
      .cfg_len   (cfg_frame_len),
      .cfg_log   (cfg_avg_log2),
      .acc       (acc),
      .acc_bin   (acc_bin),
      .acc_first (acc_first),
      .acc_last  (acc_last),
      .acc_shift (acc_shift),
      .err       (err_frame)
   );

   spa_bin_ram #(.AW(BIN_AW), .DW(SUM_W)) u_ram (
      .clk     (clk),
      .rd_en   (acc),
      .rd_addr (acc_bin),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   spa_accum #(
      .BIN_AW(BIN_AW), .POW_W(POW_W), .SUM_W(SUM_W),
      .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .acc_bin    (acc_bin),
      .acc_first  (acc_first),
      .acc_last   (acc_last),
      .acc_shift  (acc_shift),
      .pwr        (pwr),
      .thr        (cfg_threshold),
      .rd_data    (rd_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .out_valid  (out_valid),
      .out_power  (out_power),
      .out_bin    (out_bin),
      .out_detect (out_detect)
   );

   // R5
   out_after_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/tb_spec_avg_detect.sv
module tb_spec_avg_detect;
   localparam int DATA_W  = 16;
   localparam int BIN_AW  = 10;
   localparam int MAX_LOG = 8;
   localparam int POW_W   = 2*DATA_W;
   localparam int LOG_W   = $clog2(MAX_LOG + 1);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     in_valid = 1'b0;
   logic                     in_first = 1'b0;
   logic signed [DATA_W-1:0] in_re = '0;
   logic signed [DATA_W-1:0] in_im = '0;
   logic [BIN_AW:0]          cfg_frame_len = '0;
   logic [LOG_W-1:0]         cfg_avg_log2 = '0;
   logic [POW_W-1:0]         cfg_threshold = '0;
   logic                     out_valid;
   logic [POW_W-1:0]         out_power;
   logic [BIN_AW-1:0]        out_bin;
   logic                     out_detect;
   logic                     err_frame;

   spec_avg_detect dut (.*);

   always #5 clk = ~clk;

   int     checks = 0;
   int     fails  = 0;
   int     cyc    = 0;
   int     pmode  = 0;
   longint cur_thr = 0;

   int     ncap = 0;
   int     nerr = 0;
   longint cap_pow [512];
   int     cap_bin [512];
   int     cap_det [512];

   int     ne = 0;
   longint exp_pow [512];
   int     exp_bin [512];
   int     exp_det [512];
   longint msum    [16];

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && ncap < 512) begin
            cap_pow[ncap] = longint'(out_power);
            cap_bin[ncap] = int'(out_bin);
            cap_det[ncap] = int'(out_detect);
            ncap = ncap + 1;
         end
         if (err_frame) nerr = nerr + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int pat_re(int f, int b);
      if (pmode == 1) return (b == 0) ? -32768 : f;
      return ((f*37 + b*11) % 200) - 100;
   endfunction

   function automatic int pat_im(int f, int b);
      if (pmode == 1) return (b == 0) ? -32768 : -f;
      return ((f*13 + b*29) % 150) - 70;
   endfunction

   function automatic longint pw(int f, int b);
      longint r = longint'(pat_re(f, b));
      longint i = longint'(pat_im(f, b));
      return r*r + i*i;
   endfunction

   task automatic reset_dut(input int len, input int lg, input longint thr);
      in_valid = 1'b0;
      in_first = 1'b0;
      cfg_frame_len = (BIN_AW+1)'(len);
      cfg_avg_log2  = LOG_W'(lg);
      cfg_threshold = POW_W'(thr);
      cur_thr = thr;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R10
      chk(out_valid == 1'b0 && err_frame == 1'b0, "R10 quiet in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      ncap = 0;
      nerr = 0;
      ne = 0;
   endtask

   task automatic send_frame(input int f, input int nb);
      for (int b = 0; b < nb; b++) begin
         in_valid = 1'b1;
         in_first = (b == 0);
         in_re = DATA_W'(pat_re(f, b));
         in_im = DATA_W'(pat_im(f, b));
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_first = 1'b0;
   endtask

   task automatic model_frame(input int f, input int len, input int lg, input int pidx);
      for (int b = 0; b < len; b++) begin
         if (pidx == 0) msum[b] = pw(f, b);
         else           msum[b] = msum[b] + pw(f, b);
         if (pidx == (1 << lg) - 1) begin
            exp_pow[ne] = msum[b] >> lg;
            exp_bin[ne] = b;
            exp_det[ne] = (exp_pow[ne] > cur_thr) ? 1 : 0;
            ne = ne + 1;
         end
      end
   endtask

   task automatic compare(input string req, input int exp_err);
      repeat (4) @(posedge clk);
      #1;
      chk(ncap == ne, {req, " output count"}, ncap, ne);
      chk(nerr == exp_err, {req, " error pulses"}, nerr, exp_err);
      for (int i = 0; i < ne && i < ncap; i++) begin
         chk(cap_pow[i] == exp_pow[i], {req, " power"}, cap_pow[i], exp_pow[i]);
         chk(cap_bin[i] == exp_bin[i], {req, " bin index"}, cap_bin[i], exp_bin[i]);
         chk(cap_det[i] == exp_det[i], {req, " detect R4"}, cap_det[i], exp_det[i]);
      end
   endtask

   // R10: state right after reset release
   task automatic t_reset();
      reset_dut(4, 0, 0);
      @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R10 out_valid after reset", longint'(out_valid), 0);
      chk(err_frame == 1'b0, "R10 err_frame after reset", longint'(err_frame), 0);
   endtask

   // R1 R2 R4: no averaging, threshold equal to one bin's power
   task automatic t_no_avg();
      pmode = 0;
      reset_dut(8, 0, pw(0, 3));
      for (int f = 0; f < 2; f++) begin
         send_frame(f, 8);
         model_frame(f, 8, 0, 0);
      end
      compare("R2 pass-through", 0);
   endtask

   // R3: four-frame averaging over two periods
   task automatic t_avg4();
      pmode = 0;
      reset_dut(8, 2, 3000);
      for (int f = 0; f < 8; f++) begin
         send_frame(f, 8);
         model_frame(f, 8, 2, f % 4);
      end
      compare("R3 average of 4", 0);
   endtask

   // R1 R3: 256-frame period at full scale
   task automatic t_extreme();
      pmode = 1;
      reset_dut(2, 8, 64'h7FFF_FFFF);
      for (int f = 0; f < 256; f++) begin
         send_frame(f, 2);
         model_frame(f, 2, 8, f);
      end
      compare("R1 R3 full scale", 0);
      chk(ne == 2 && exp_pow[0] == 64'h8000_0000, "R1 model full scale", exp_pow[0], 64'h8000_0000);
      pmode = 0;
   endtask

   // R6: same bin every clock
   task automatic t_len1();
      pmode = 0;
      reset_dut(1, 1, 5000);
      for (int f = 0; f < 6; f++) begin
         send_frame(f, 1);
         model_frame(f, 1, 1, f % 2);
      end
      compare("R6 back-to-back bin", 0);
   endtask

   // R5: output timing
   task automatic t_latency();
      pmode = 0;
      reset_dut(1, 0, 0);
      in_valid = 1'b1;
      in_first = 1'b1;
      in_re = 16'sd3;
      in_im = -16'sd4;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_first = 1'b0;
      chk(out_valid == 1'b0, "R5 not early", longint'(out_valid), 0);
      @(posedge clk);
      #1;
      chk(out_valid == 1'b1, "R5 valid on time", longint'(out_valid), 1);
      chk(out_power == 25, "R5 R1 power value", longint'(out_power), 25);
      chk(out_detect == 1'b1, "R5 R4 detect", longint'(out_detect), 1);
      @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R5 single cycle", longint'(out_valid), 0);
   endtask

   // R7: short frame inside a period
   task automatic t_short();
      pmode = 0;
      reset_dut(4, 2, 4000);
      send_frame(0, 4);
      send_frame(1, 4);
      send_frame(2, 2);
      for (int k = 0; k < 4; k++) begin
         send_frame(10 + k, 4);
         model_frame(10 + k, 4, 2, k);
      end
      compare("R7 short frame", 1);
   endtask

   // R8: overlong frame, stray bins dropped
   task automatic t_long();
      pmode = 0;
      reset_dut(4, 1, 4000);
      send_frame(0, 6);
      for (int k = 0; k < 2; k++) begin
         send_frame(20 + k, 4);
         model_frame(20 + k, 4, 1, k);
      end
      compare("R8 long frame", 1);
   endtask

   // R9: bins before any frame start
   task automatic t_idle_ignore();
      pmode = 0;
      reset_dut(4, 0, 2000);
      for (int b = 0; b < 3; b++) begin
         in_valid = 1'b1;
         in_first = 1'b0;
         in_re = 16'sd100;
         in_im = 16'sd100;
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(ncap == 0, "R9 no output from stray bins", ncap, 0);
      chk(nerr == 0, "R9 no error from stray bins", nerr, 0);
      send_frame(5, 4);
      model_frame(5, 4, 0, 0);
      compare("R9 after stray bins", 0);
   endtask

   initial begin
      t_reset();
      t_no_avg();
      t_avg4();
      t_extreme();
      t_len1();
      t_latency();
      t_short();
      t_long();
      t_idle_ignore();
      summary();
      $finish;
   end
endmodule